// File: doc/BRIEF.md
# Port Enable and Suspend Control

This block decides, for every cable port of a multi-port serial bus node, whether that port's line transceiver and its termination bias supply should be running. It drives two registered enables per port. The transceiver enable and the bias enable are gated by different sets of conditions. Transceiver traffic stops whenever the port has no cable attached, is held off by the arbitration logic, or is suspended. The bias supply stops only when the link layer has switched the port off. A global power-down input and the node reset turn both enables off.

The block also drives two node-wide signals. A cable-idle flag is derived combinationally from the connect inputs. It is not filtered, so it reports a change in the same cycle, and it keeps working while power-down is asserted. A registered deep-sleep flag rises once every port is suspended, and the power manager uses it to shut down everything apart from the reference and bias-detection circuits. Connection detection and analog bias generation lie outside the block and reach it as plain digital inputs.

The reset input is active low. It clears every registered output at once, without waiting for a clock edge. Its release passes through a two-stage synchronizer, so the outputs first follow the inputs at the third rising clock edge after the release.

Top module: `port_enable_ctrl`

## Requirements
- R1: One clock edge after its inputs settle, xcvr_en[i] is 1 exactly when pwr_down is 0, cable_conn[i] is 1, arb_off[i] is 0 and port_susp[i] is 0.
- R2: One clock edge after its inputs settle, bias_en[i] is 1 exactly when pwr_down is 0 and link_off[i] is 0, whatever the values of cable_conn[i], arb_off[i] and port_susp[i].
- R3: cable_idle is 1 exactly when every bit of cable_conn is 0. It follows cable_conn within the same cycle with no clock edge, and it keeps doing so while pwr_down is 1.
- R4: One clock edge after its inputs settle, deep_sleep is 1 exactly when every bit of port_susp is 1.
- R5: While rst_n is 0, xcvr_en, bias_en and deep_sleep are all 0. They clear as soon as rst_n falls, with no clock edge needed.
- R6: After rst_n rises, all registered outputs stay 0 through the first two rising clock edges and take their input-derived values at the third.
- R7: Each port's enables depend only on that port's own cable_conn, arb_off, link_off and port_susp bits, together with pwr_down.
- R8: While pwr_down is 1, every xcvr_en and bias_en bit is 0 one clock edge later, whatever the per-port inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Node reset, active low, asynchronous assertion |
| pwr_down | input | 1 | Global power-down request, active high |
| cable_conn | input | NUM_PORTS | Cable detected on the port |
| arb_off | input | NUM_PORTS | Arbitration logic holds the port transceiver off |
| link_off | input | NUM_PORTS | Link layer has commanded the port disabled |
| port_susp | input | NUM_PORTS | Port is in the suspended low-power state |
| xcvr_en | output | NUM_PORTS | Registered transceiver enable per port |
| bias_en | output | NUM_PORTS | Registered bias supply enable per port |
| cable_idle | output | 1 | No port has a cable (combinational, unfiltered) |
| deep_sleep | output | 1 | Registered flag: all ports suspended |

## Verification
A stuck or mis-gated enable register appears on xcvr_en or bias_en one clock edge after the offending input pattern. A sweep over every combination of power-down and the per-port inputs therefore exposes any wrong term, or any term crossed between ports, within a single cycle. A synchronizer that is too short or too long shows up as the enables rising at the wrong edge after reset release, so that window is checked edge by edge. A wrongly registered or filtered cable_idle shows up as a mismatch read without any clock edge after cable_conn changes.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int unsigned PEC_PORTS_DFLT = 3;
  localparam int unsigned PEC_SYNC_DFLT  = 2;

  typedef struct packed {
    logic xcvr;
    logic bias;
  } port_en_t;
endpackage

// File: rtl/pec_rst_sync.sv
module pec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok = chain_q[STAGES-1];
endmodule

// File: rtl/pec_port_gate.sv
module pec_port_gate
  import pec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ok,
  input  logic     pwr_down,
  input  logic     conn,
  input  logic     arb_off,
  input  logic     link_off,
  input  logic     susp,
  output port_en_t en
);
  port_en_t en_d;

  always_comb begin
    // transceiver: needs a cable, arbitration consent, and an awake port
    en_d.xcvr = !pwr_down && conn && !arb_off && !susp;
    // bias: only the link command and power-down switch it off
    en_d.bias = !pwr_down && !link_off;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) en <= '0;
    else         en <= en_d;
  end
endmodule

// File: rtl/pec_sleep_detect.sv
module pec_sleep_detect #(
  parameter int unsigned NUM_PORTS = 3
) (
  input  logic                 clk,
  input  logic                 rst_ok,
  input  logic [NUM_PORTS-1:0] port_susp,
  output logic                 deep_sleep
);
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) deep_sleep <= 1'b0;
    else         deep_sleep <= &port_susp;
  end
endmodule

// File: rtl/port_enable_ctrl.sv
module port_enable_ctrl
  import pec_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = PEC_PORTS_DFLT,
  parameter int unsigned SYNC_STAGES = PEC_SYNC_DFLT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_down,
  input  logic [NUM_PORTS-1:0] cable_conn,
  input  logic [NUM_PORTS-1:0] arb_off,
  input  logic [NUM_PORTS-1:0] link_off,
  input  logic [NUM_PORTS-1:0] port_susp,
  output logic [NUM_PORTS-1:0] xcvr_en,
  output logic [NUM_PORTS-1:0] bias_en,
  output logic                 cable_idle,
  output logic                 deep_sleep
);
  logic rst_ok;

  pec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    port_en_t en_q;

    pec_port_gate u_gate (
      .clk      (clk),
      .rst_ok   (rst_ok),
      .pwr_down (pwr_down),
      .conn     (cable_conn[p]),
      .arb_off  (arb_off[p]),
      .link_off (link_off[p]),
      .susp     (port_susp[p]),
      .en       (en_q)
    );

    assign xcvr_en[p] = en_q.xcvr;
    assign bias_en[p] = en_q.bias;
  end

  pec_sleep_detect #(.NUM_PORTS(NUM_PORTS)) u_sleep (
    .clk        (clk),
    .rst_ok     (rst_ok),
    .port_susp  (port_susp),
    .deep_sleep (deep_sleep)
  );

  // unfiltered, live through power-down
  assign cable_idle = ~|cable_conn;
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int unsigned NUM_PORTS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_ok,
  input logic                 pwr_down,
  input logic [NUM_PORTS-1:0] cable_conn,
  input logic [NUM_PORTS-1:0] arb_off,
  input logic [NUM_PORTS-1:0] link_off,
  input logic [NUM_PORTS-1:0] port_susp,
  input logic [NUM_PORTS-1:0] xcvr_en,
  input logic [NUM_PORTS-1:0] bias_en,
  input logic                 cable_idle,
  input logic                 deep_sleep
);
  // R1: a blocked port never shows its transceiver enabled
  a_r1_blocked_xcvr_off: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ok && $past(rst_ok) |->
      (xcvr_en & $past(~cable_conn | arb_off | port_susp)) == '0);

  // R2: bias follows link command alone when not powered down
  a_r2_bias_link: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ok && $past(rst_ok) && !$past(pwr_down) |->
      (bias_en ^ ~$past(link_off)) == '0);

  // R3: with no cable anywhere, no transceiver may be on next cycle
  a_r3_idle_no_xcvr: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ok && $past(rst_ok) && $past(cable_idle) |-> xcvr_en == '0);

  // R4: deep sleep tracks the all-suspended condition
  a_r4_sleep_all_susp: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ok && $past(rst_ok) |-> deep_sleep == ($past(port_susp) == '1));

  // R5: reset holds every registered output low
  a_r5_reset_clears: assert property (@(posedge clk)
    !rst_n |-> xcvr_en == '0 && bias_en == '0 && !deep_sleep);

  // R6: nothing enabled on the edge the synchronizer releases
  a_r6_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_ok) |-> xcvr_en == '0 && bias_en == '0 && !deep_sleep);

  // R8: power-down overrides all per-port inputs
  a_r8_pd_override: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ok && $past(rst_ok) && $past(pwr_down) |->
      xcvr_en == '0 && bias_en == '0);
endmodule

bind port_enable_ctrl pec_checker #(.NUM_PORTS(NUM_PORTS)) u_pec_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_ok     (rst_ok),
  .pwr_down   (pwr_down),
  .cable_conn (cable_conn),
  .arb_off    (arb_off),
  .link_off   (link_off),
  .port_susp  (port_susp),
  .xcvr_en    (xcvr_en),
  .bias_en    (bias_en),
  .cable_idle (cable_idle),
  .deep_sleep (deep_sleep)
);

// File: tb/tb_port_enable_ctrl.sv
module tb_port_enable_ctrl;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pwr_down;
  logic [N-1:0] cable_conn, arb_off, link_off, port_susp;
  logic [N-1:0] xcvr_en, bias_en;
  logic         cable_idle, deep_sleep;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  port_enable_ctrl #(.NUM_PORTS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .cable_conn(cable_conn), .arb_off(arb_off), .link_off(link_off),
    .port_susp(port_susp), .xcvr_en(xcvr_en), .bias_en(bias_en),
    .cable_idle(cable_idle), .deep_sleep(deep_sleep)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic all_low(input string req);
    chk(req, {5'b0, xcvr_en}, 8'h0);
    chk(req, {5'b0, bias_en}, 8'h0);
    chk(req, {7'b0, deep_sleep}, 8'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ex_x, ex_b;
    rst_n = 1'b0; pwr_down = 1'b0;
    cable_conn = '1; arb_off = '0; link_off = '0; port_susp = '0;
    repeat (3) @(posedge clk);
    #2;
    all_low("R5 reset state");

    // R6: release between edges, expect enables only at the third edge
    rst_n = 1'b1;
    @(posedge clk); #2; all_low("R6 edge1");
    @(posedge clk); #2; all_low("R6 edge2");
    @(posedge clk); #2;
    chk("R6 edge3 xcvr", {5'b0, xcvr_en}, 8'h7);
    chk("R6 edge3 bias", {5'b0, bias_en}, 8'h7);

    // R5: asynchronous clear, no clock edge between
    #1 rst_n = 1'b0;
    #1 all_low("R5 async clear");
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;

    // exhaustive sweep over pwr_down and all per-port inputs (R1 R2 R3 R4 R7 R8)
    for (int p = 0; p < (1 << 13); p++) begin
      cable_conn = p[2:0];
      arb_off    = p[5:3];
      link_off   = p[8:6];
      port_susp  = p[11:9];
      pwr_down   = p[12];
      #1;
      chk("R3 cable_idle", {7'b0, cable_idle}, {7'b0, (p[2:0] == 3'b000)});
      for (int i = 0; i < N; i++) begin
        ex_x[i] = !p[12] && p[i] && !p[3+i] && !p[9+i];
        ex_b[i] = !p[12] && !p[6+i];
      end
      @(posedge clk); #2;
      if (p[12]) begin
        chk("R8 xcvr pd", {5'b0, xcvr_en}, 8'h0);
        chk("R8 bias pd", {5'b0, bias_en}, 8'h0);
      end else begin
        chk("R1/R7 xcvr", {5'b0, xcvr_en}, {5'b0, ex_x});
        chk("R2/R7 bias", {5'b0, bias_en}, {5'b0, ex_b});
      end
      chk("R4 deep_sleep", {7'b0, deep_sleep}, {7'b0, (p[11:9] == 3'b111)});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule